// File: doc/BRIEF.md
# Indexed Command-Data Register Port

This block gives an external microprocessor access to a bank of internal 16-bit control registers through two I/O locations. The host first writes a register index to the command location. It then reads or writes a data word through the data location. The address line selects between the two locations. The chip select and the read and write strobes are active low. The 16-bit bidirectional bus is modelled as separate input and output buses plus an output enable.

The register bank holds a parameterised run of writable registers and one read-only identification register that returns a fixed word. The chosen index stays latched after each data access, so a register can be read or written many times after a single command. The host strobes are brought into the system clock domain through a synchronizer. A write is recognised on the synchronised falling edge of the write strobe. Read data is driven combinationally while the chip select and read strobe are both low.

Top module: `cdp_port`

## Requirements
- R1: After reset the latched index is 00h, every writable register is 0000h, and the output enable is low.
- R2: While chip select is high, write strobes have no effect on the index or the registers, and the output enable stays low.
- R3: A write with the address line at 1 latches data bits 7:0 as the index. Bits 15:8 are ignored even when they are nonzero.
- R4: A write with the address line at 0 stores the 16-bit word in the register selected by the index, when the index is in the writable range (default 20h to 23h). A later data read returns that word.
- R5: While the index is 27h, a data read returns the chip ID (default C0DEh), and a data write leaves that value unchanged.
- R6: At an index that is neither writable nor 27h, a data read returns 0000h and a data write changes no register.
- R7: A read with the address line at 1 returns 0000h and leaves the latched index unchanged.
- R8: The index persists across data accesses, so successive data accesses all reach the same register until a new command is written.
- R9: The output enable is high exactly while chip select and the read strobe are both low. A write takes effect by the SYNC_STAGES+1 rising clock edge after the write strobe falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| a0 | input | 1 | Location select: 1 = command, 0 = data |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| din | input | 16 | Bus data from the host |
| dout | output | 16 | Bus data to the host |
| dout_oe | output | 1 | Output enable for dout |

## Verification
The read path is combinational, so dout and dout_oe are due in the same cycle that the strobe and chip select are driven. The bench samples them one nanosecond after driving, before the next clock edge. A write passes through two synchronizer stages and one edge-detect register, so it lands on the third rising edge after the strobe falls. The bench holds each write strobe low for four cycles and waits four more cycles after release before any read-back. Every check therefore falls well after the update is due.

// File: rtl/cdp_pkg.sv
package cdp_pkg;
    localparam int DATA_W = 16;
    localparam int IDX_W  = 8;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef struct packed {
        idx_t index;
        logic wr_prev;
    } port_state_t;
endpackage

// File: rtl/cdp_sync.sv
module cdp_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe_q[i] <= RST_VAL;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/cdp_regfile.sv
module cdp_regfile
    import cdp_pkg::*;
#(
    parameter int    WR_BASE  = 'h20,
    parameter int    WR_COUNT = 4,
    parameter int    ID_INDEX = 'h27,
    parameter word_t CHIP_ID  = 16'hC0DE
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  idx_t  idx,
    input  word_t wdata,
    output word_t rdata
);
    localparam int XW = IDX_W + 1;

    typedef struct packed {
        logic [WR_COUNT-1:0][DATA_W-1:0] regs;
    } rf_state_t;

    rf_state_t st_d, st_q;
    logic [XW-1:0] idx_x;

    assign idx_x = {1'b0, idx};

    always_comb begin
        st_d  = st_q;
        rdata = '0;
        if (idx_x == XW'(ID_INDEX)) begin
            rdata = CHIP_ID;
        end
        for (int i = 0; i < WR_COUNT; i++) begin
            if (idx_x == XW'(WR_BASE + i)) begin
                rdata = st_q.regs[i];
                if (we) st_d.regs[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/cdp_port.sv
module cdp_port
    import cdp_pkg::*;
#(
    parameter int    WR_BASE     = 'h20,
    parameter int    WR_COUNT    = 4,
    parameter int    ID_INDEX    = 'h27,
    parameter word_t CHIP_ID     = 16'hC0DE,
    parameter int    SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cs_n,
    input  logic        a0,
    input  logic        rd_n,
    input  logic        wr_n,
    input  logic [15:0] din,
    output logic [15:0] dout,
    output logic        dout_oe
);
    localparam int BUS_W = DATA_W + 3;

    logic [BUS_W-1:0] bus_sync;
    logic  s_cs_n, s_a0, s_wr_n;
    word_t s_din;
    logic  wr_fall, cmd_we, data_we;
    word_t rf_rdata;

    port_state_t st_d, st_q;

    cdp_sync #(
        .W       (BUS_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({1'b1, 1'b0, 1'b1, {DATA_W{1'b0}}})
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({cs_n, a0, wr_n, din}),
        .q   (bus_sync)
    );

    assign {s_cs_n, s_a0, s_wr_n, s_din} = bus_sync;

    always_comb begin
        st_d         = st_q;
        st_d.wr_prev = s_wr_n;
        wr_fall      = st_q.wr_prev & ~s_wr_n;
        cmd_we       = wr_fall & ~s_cs_n & s_a0;
        data_we      = wr_fall & ~s_cs_n & ~s_a0;
        if (cmd_we) st_d.index = s_din[IDX_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.index   <= '0;
            st_q.wr_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    cdp_regfile #(
        .WR_BASE  (WR_BASE),
        .WR_COUNT (WR_COUNT),
        .ID_INDEX (ID_INDEX),
        .CHIP_ID  (CHIP_ID)
    ) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (data_we),
        .idx   (st_q.index),
        .wdata (s_din),
        .rdata (rf_rdata)
    );

    assign dout_oe = ~cs_n & ~rd_n;
    assign dout    = a0 ? '0 : rf_rdata;
endmodule

// File: rtl/cdp_port_checker.sv
module cdp_port_checker #(
    parameter int          WR_BASE  = 'h20,
    parameter int          WR_COUNT = 4,
    parameter int          ID_INDEX = 'h27,
    parameter logic [15:0] CHIP_ID  = 16'hC0DE
) (
    input logic        clk,
    input logic        rst,
    input logic        cs_n,
    input logic        a0,
    input logic        s_cs_n,
    input logic        cmd_we,
    input logic        data_we,
    input logic [7:0]  index,
    input logic [15:0] dout,
    input logic        dout_oe
);
    logic unimpl;
    assign unimpl = ({1'b0, index} != 9'(ID_INDEX)) &&
                    (({1'b0, index} < 9'(WR_BASE)) ||
                     ({1'b0, index} >= 9'(WR_BASE + WR_COUNT)));

    assert_reset_index_R1: assert property (@(posedge clk)
        rst |=> index == 8'h00);

    assert_oe_idle_R2: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !dout_oe);

    assert_no_write_deselected_R2: assert property (@(posedge clk) disable iff (rst)
        s_cs_n |-> (!cmd_we && !data_we));

    assert_id_read_R5: assert property (@(posedge clk) disable iff (rst)
        (!a0 && index == 8'(ID_INDEX)) |-> dout == CHIP_ID);

    assert_unimpl_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (!a0 && unimpl) |-> dout == 16'h0000);

    assert_cmd_read_zero_R7: assert property (@(posedge clk) disable iff (rst)
        a0 |-> dout == 16'h0000);

    assert_index_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !cmd_we |=> $stable(index));
endmodule

bind cdp_port cdp_port_checker #(
    .WR_BASE  (WR_BASE),
    .WR_COUNT (WR_COUNT),
    .ID_INDEX (ID_INDEX),
    .CHIP_ID  (CHIP_ID)
) u_cdp_port_checker (
    .clk     (clk),
    .rst     (rst),
    .cs_n    (cs_n),
    .a0      (a0),
    .s_cs_n  (s_cs_n),
    .cmd_we  (cmd_we),
    .data_we (data_we),
    .index   (st_q.index),
    .dout    (dout),
    .dout_oe (dout_oe)
);

// File: tb/cdp_port_bench.sv
`timescale 1ns/1ps
module cdp_port_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        cs_n, a0, rd_n, wr_n;
    logic [15:0] din;
    logic [15:0] dout;
    logic        dout_oe;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    cdp_port u_cdp_port (
        .clk(clk), .rst(rst), .cs_n(cs_n), .a0(a0), .rd_n(rd_n),
        .wr_n(wr_n), .din(din), .dout(dout), .dout_oe(dout_oe)
    );

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic sel, logic [15:0] value, logic csn);
        @(negedge clk);
        cs_n = csn; a0 = sel; din = value; wr_n = 1'b0;
        repeat (4) @(negedge clk);
        wr_n = 1'b1;
        repeat (1) @(negedge clk);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic bus_read(logic sel, output logic [15:0] value, output logic oe);
        @(negedge clk);
        cs_n = 1'b0; a0 = sel; rd_n = 1'b0;
        #1;
        value = dout; oe = dout_oe;
        @(negedge clk);
        rd_n = 1'b1; cs_n = 1'b1;
    endtask

    task automatic test_reset();
        logic [15:0] v; logic oe;
        check("R1 oe after reset", {15'd0, dout_oe}, 16'd0);
        bus_read(1'b0, v, oe);
        check("R1 index 00 reads zero", v, 16'h0000);
        bus_write(1'b1, 16'h0020, 1'b0);
        bus_read(1'b0, v, oe);
        check("R1 register cleared", v, 16'h0000);
        check("R9 oe during read", {15'd0, oe}, 16'd1);
    endtask

    task automatic test_write_read();
        logic [15:0] v; logic oe;
        for (int i = 0; i < 4; i++) begin
            bus_write(1'b1, 16'h0020 + 16'(i), 1'b0);
            bus_write(1'b0, 16'hA5A0 + 16'(i * 17), 1'b0);
        end
        for (int i = 3; i >= 0; i--) begin
            bus_write(1'b1, 16'h0020 + 16'(i), 1'b0);
            bus_read(1'b0, v, oe);
            check("R4 readback", v, 16'hA5A0 + 16'(i * 17));
        end
    endtask

    task automatic test_high_byte();
        logic [15:0] v; logic oe;
        bus_write(1'b1, 16'hFF21, 1'b0);
        bus_read(1'b0, v, oe);
        check("R3 high byte ignored", v, 16'hA5B1);
    endtask

    task automatic test_hold();
        logic [15:0] v; logic oe;
        bus_write(1'b1, 16'h0022, 1'b0);
        bus_write(1'b0, 16'h1234, 1'b0);
        bus_read(1'b0, v, oe);
        check("R8 first access", v, 16'h1234);
        bus_write(1'b0, 16'h5678, 1'b0);
        bus_read(1'b0, v, oe);
        check("R8 same register", v, 16'h5678);
        bus_read(1'b0, v, oe);
        check("R8 repeated read", v, 16'h5678);
    endtask

    task automatic test_id();
        logic [15:0] v; logic oe;
        bus_write(1'b1, 16'h0027, 1'b0);
        bus_read(1'b0, v, oe);
        check("R5 chip id", v, 16'hC0DE);
        bus_write(1'b0, 16'hFFFF, 1'b0);
        bus_read(1'b0, v, oe);
        check("R5 id unchanged", v, 16'hC0DE);
    endtask

    task automatic test_unimpl();
        logic [15:0] v; logic oe;
        bus_write(1'b1, 16'h0030, 1'b0);
        bus_write(1'b0, 16'hBEEF, 1'b0);
        bus_read(1'b0, v, oe);
        check("R6 unimplemented reads zero", v, 16'h0000);
        bus_write(1'b1, 16'h0020, 1'b0);
        bus_read(1'b0, v, oe);
        check("R6 neighbour untouched", v, 16'hA5A0);
    endtask

    task automatic test_cmd_read();
        logic [15:0] v; logic oe;
        bus_write(1'b1, 16'h0023, 1'b0);
        bus_read(1'b1, v, oe);
        check("R7 command read zero", v, 16'h0000);
        bus_read(1'b0, v, oe);
        check("R7 index unchanged", v, 16'hA5D3);
    endtask

    task automatic test_deselect();
        logic [15:0] v; logic oe;
        bus_write(1'b1, 16'h0021, 1'b1);
        bus_write(1'b0, 16'h0BAD, 1'b1);
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b0; a0 = 1'b0;
        #1;
        check("R2 oe low when deselected", {15'd0, dout_oe}, 16'd0);
        check("R9 oe low when deselected", {15'd0, dout_oe}, 16'd0);
        rd_n = 1'b1;
        bus_read(1'b0, v, oe);
        check("R2 register kept", v, 16'hA5D3);
    endtask

    initial begin
        rst = 1'b1; cs_n = 1'b1; a0 = 1'b0; rd_n = 1'b1; wr_n = 1'b1; din = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_write_read();
        test_high_byte();
        test_hold();
        test_id();
        test_unimpl();
        bus_write(1'b1, 16'h0022, 1'b0);
        bus_write(1'b0, 16'hA5C2, 1'b0);
        test_cmd_read();
        test_deselect();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule